// File: doc/BRIEF.md
# Two-Byte Conversion Result Register with Read Lock

This block sits between a conversion engine and a CPU register bus. Each time the engine reports a finished conversion it hands over a 10-bit result. The block stores that result, packed into two byte-wide read registers, and raises a conversion-complete interrupt flag. The alignment control bit chooses the packing. With the bit clear the value is justified toward bit 0 of the pair. With the bit set it is justified toward the top of the pair, so a reader who needs only 8 bits can fetch the high byte alone.

The two bytes must come from the same conversion. To guarantee this, a read of the low byte freezes both registers. They stay frozen until the high byte is read. A conversion that finishes while the registers are frozen is thrown away. The interrupt flag is still set for it. Software clears the flag by writing a one to it.

Top module: `adc_result_latch`

## Requirements
- R1: After reset both result bytes read 0, the interrupt flag is 0, and the registers are unlocked.
- R2: With the alignment bit at 0, an accepted result d appears in the cycle after its strobe as high byte = {6'b0, d[9:8]} and low byte = d[7:0].
- R3: With the alignment bit at 1, an accepted result d appears as high byte = d[9:2] and low byte = {d[1:0], 6'b0}.
- R4: A change of the alignment bit leaves a result already held unchanged. It applies from the next stored result on.
- R5: A low-byte read strobe locks the registers. A result whose strobe comes in the same cycle as that read, or in any later cycle before a high-byte read, changes neither byte.
- R6: A high-byte read strobe unlocks the registers from the next cycle. A result that arrives in the same cycle as that read is still discarded.
- R7: High-byte reads on their own never lock the registers, so results keep updating both bytes.
- R8: The interrupt flag is 1 in the cycle after every result strobe, whether the result was stored or discarded.
- R9: A clear strobe (a write of one to the flag) makes the flag 0 in the next cycle. If a result strobe comes in the same cycle, the set wins.
- R10: Low-byte and high-byte read strobes in the same cycle make one complete read. The registers are unlocked afterwards, and a result in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done_i | input | 1 | One-cycle strobe: a conversion has finished |
| conv_data_i | input | RES_W | Result that goes with the strobe |
| left_align_i | input | 1 | 0 = right-justified packing, 1 = left-justified packing |
| rd_lo_i | input | 1 | Bus read of the low result byte |
| rd_hi_i | input | 1 | Bus read of the high result byte |
| flag_clr_i | input | 1 | Bus write of one to the interrupt flag |
| res_lo_o | output | BYTE_W | Low result byte |
| res_hi_o | output | BYTE_W | High result byte |
| irq_flag_o | output | 1 | Conversion-complete interrupt flag |

## Verification
The bench builds the block with its defaults, RES_W = 10 and BYTE_W = 8. That width pair leaves six padding bits in each packing. It therefore exposes any padding that is not zero and any misplaced pair of bits in both alignments.

The stimulus covers the edges of the lock window:
- a result in the same cycle as a low-byte read;
- a result in the same cycle as a high-byte read;
- both read strobes together;
- a clear strobe colliding with a result strobe.

It also toggles the alignment bit while a result is held.

// File: rtl/adc_rl_pkg.sv
package adc_rl_pkg;

  typedef enum logic {
    ALIGN_RIGHT = 1'b0,
    ALIGN_LEFT  = 1'b1
  } align_e;

  typedef enum logic {
    GATE_OPEN = 1'b0,
    GATE_HELD = 1'b1
  } gate_e;

endpackage

// File: rtl/adc_rl_format.sv
module adc_rl_format
  import adc_rl_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  data_i,
  input  align_e            align_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o
);

  localparam int WIDE_W = 2 * BYTE_W;
  localparam int PAD_W  = WIDE_W - RES_W;

  // value sits against bit 0 of the pair
  function automatic logic [WIDE_W-1:0] place_right(input logic [RES_W-1:0] d);
    return WIDE_W'(d);
  endfunction

  // value sits against the top bit of the pair
  function automatic logic [WIDE_W-1:0] place_left(input logic [RES_W-1:0] d);
    return WIDE_W'(d) << PAD_W;
  endfunction

  logic [WIDE_W-1:0] wide;

  always_comb begin
    if (align_i == ALIGN_LEFT) wide = place_left(data_i);
    else                       wide = place_right(data_i);
    hi_o = wide[WIDE_W-1:BYTE_W];
    lo_o = wide[BYTE_W-1:0];
  end

endmodule

// File: rtl/adc_rl_gate.sv
module adc_rl_gate
  import adc_rl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_lo_i,
  input  logic rd_hi_i,
  input  logic done_i,
  output logic held_o,
  output logic store_o,
  output logic drop_o
);

  gate_e state_q, state_d;
  logic  blocked;

  // a low read in this cycle already protects the bytes being read
  assign blocked = (state_q == GATE_HELD) || rd_lo_i;
  assign store_o = done_i && !blocked;
  assign drop_o  = done_i && blocked;
  assign held_o  = (state_q == GATE_HELD);

  always_comb begin
    state_d = state_q;
    if (rd_hi_i)      state_d = GATE_OPEN;
    else if (rd_lo_i) state_d = GATE_HELD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GATE_OPEN;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/adc_rl_store.sv
module adc_rl_store #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic [BYTE_W-1:0] lo_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_o <= '0;
      lo_o <= '0;
    end else if (we_i) begin
      hi_o <= hi_i;
      lo_o <= lo_i;
    end
  end

endmodule

// File: rtl/adc_rl_flag.sv
module adc_rl_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch
  import adc_rl_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_data_i,
  input  logic              left_align_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  input  logic              flag_clr_i,
  output logic [BYTE_W-1:0] res_lo_o,
  output logic [BYTE_W-1:0] res_hi_o,
  output logic              irq_flag_o
);

  // internal events brought out under their own names
  logic              store_ev;
  logic              drop_ev;
  logic              gate_held;
  logic [BYTE_W-1:0] fmt_hi;
  logic [BYTE_W-1:0] fmt_lo;

  adc_rl_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_format (
    .data_i  (conv_data_i),
    .align_i (align_e'(left_align_i)),
    .hi_o    (fmt_hi),
    .lo_o    (fmt_lo)
  );

  adc_rl_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_lo_i (rd_lo_i),
    .rd_hi_i (rd_hi_i),
    .done_i  (conv_done_i),
    .held_o  (gate_held),
    .store_o (store_ev),
    .drop_o  (drop_ev)
  );

  adc_rl_store #(.BYTE_W(BYTE_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (store_ev),
    .hi_i  (fmt_hi),
    .lo_i  (fmt_lo),
    .hi_o  (res_hi_o),
    .lo_o  (res_lo_o)
  );

  adc_rl_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (store_ev || drop_ev),
    .clr_i  (flag_clr_i),
    .flag_o (irq_flag_o)
  );

endmodule

// File: rtl/adc_rl_chk.sv
module adc_rl_chk #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_done_i,
  input logic              left_align_i,
  input logic              rd_lo_i,
  input logic              rd_hi_i,
  input logic              flag_clr_i,
  input logic [BYTE_W-1:0] res_lo_o,
  input logic [BYTE_W-1:0] res_hi_o,
  input logic              irq_flag_o,
  input logic              store_ev,
  input logic              drop_ev,
  input logic              gate_held
);

  localparam int PAD_W = 2 * BYTE_W - RES_W;
  localparam int TOP_W = RES_W - BYTE_W;

  // R2
  right_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_ev && !left_align_i) |=> ((res_hi_o >> TOP_W) == '0));

  // R3
  left_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_ev && left_align_i) |=> (res_lo_o[PAD_W-1:0] == '0));

  // R5
  frozen_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_held || rd_lo_i) |=> ($stable(res_lo_o) && $stable(res_hi_o)));

  // R5
  lo_read_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo_i && !rd_hi_i) |=> gate_held);

  // R6
  hi_read_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi_i |=> !gate_held);

  // R8
  flag_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done_i |=> irq_flag_o);

  // R8
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({store_ev, drop_ev}) == (conv_done_i ? 1 : 0));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !conv_done_i) |=> !irq_flag_o);

endmodule

bind adc_result_latch adc_rl_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_rl_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .conv_done_i  (conv_done_i),
  .left_align_i (left_align_i),
  .rd_lo_i      (rd_lo_i),
  .rd_hi_i      (rd_hi_i),
  .flag_clr_i   (flag_clr_i),
  .res_lo_o     (res_lo_o),
  .res_hi_o     (res_hi_o),
  .irq_flag_o   (irq_flag_o),
  .store_ev     (store_ev),
  .drop_ev      (drop_ev),
  .gate_held    (gate_held)
);

// File: tb/test_adc_result_latch.sv
`timescale 1ns/1ps
module test_adc_result_latch;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_done_i = 1'b0;
  logic [9:0] conv_data_i = '0;
  logic       left_align_i = 1'b0;
  logic       rd_lo_i = 1'b0;
  logic       rd_hi_i = 1'b0;
  logic       flag_clr_i = 1'b0;
  logic [7:0] res_lo_o, res_hi_o;
  logic       irq_flag_o;

  always #2 clk = ~clk;

  adc_result_latch i_adc_result_latch (
    .clk (clk), .rst_n (rst_n), .conv_done_i (conv_done_i), .conv_data_i (conv_data_i),
    .left_align_i (left_align_i), .rd_lo_i (rd_lo_i), .rd_hi_i (rd_hi_i),
    .flag_clr_i (flag_clr_i), .res_lo_o (res_lo_o), .res_hi_o (res_hi_o),
    .irq_flag_o (irq_flag_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done_run = 0;

  // behavioural reference state
  int m_hi = 0, m_lo = 0, m_flag = 0;
  bit m_lock = 0;

  task automatic compare(input string tag);
    n_cmp++;
    if (res_hi_o !== m_hi[7:0] || res_lo_o !== m_lo[7:0] || irq_flag_o !== m_flag[0]) begin
      n_bad++;
      $display("FAIL %s: hi=%0h lo=%0h flag=%0b expected hi=%0h lo=%0h flag=%0b",
               tag, res_hi_o, res_lo_o, irq_flag_o, m_hi, m_lo, m_flag);
    end
  endtask

  task automatic step(input bit done, input int data, input bit left, input bit lo,
                      input bit hi, input bit clr, input string tag);
    int full;
    conv_done_i = done; conv_data_i = data[9:0]; left_align_i = left;
    rd_lo_i = lo; rd_hi_i = hi; flag_clr_i = clr;
    if (done && !m_lock && !lo) begin
      full = left ? (data * 64) : data;
      m_hi = full / 256;
      m_lo = full % 256;
    end
    if (hi) m_lock = 0;
    else if (lo) m_lock = 1;
    if (done) m_flag = 1;
    else if (clr) m_flag = 0;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input bit left, input string tag);
    step(0, 0, left, 0, 0, 0, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done_run) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // R2 right alignment, several patterns
    step(1, 10'h3A5, 0, 0, 0, 0, "R2 right 3A5");
    step(1, 10'h1FF, 0, 0, 0, 0, "R2 right 1FF");
    step(1, 10'h200, 0, 0, 0, 0, "R2 right 200");
    // R9 clear, then clear colliding with done
    step(0, 0, 0, 0, 0, 1, "R9 clear");
    step(1, 10'h055, 0, 0, 0, 1, "R9 set wins");
    step(0, 0, 0, 0, 0, 1, "R9 clear again");
    // R3 left alignment
    step(1, 10'h3A5, 1, 0, 0, 0, "R3 left 3A5");
    step(1, 10'h003, 1, 0, 0, 0, "R3 left 003");
    // R4 alignment flip on held data
    idle(0, "R4 flip to right");
    idle(1, "R4 flip to left");
    step(1, 10'h2C7, 0, 0, 0, 0, "R4 next result right");
    // R5 low read locks, same-cycle done dropped
    step(1, 10'h111, 0, 1, 0, 0, "R5 done with lo read");
    step(1, 10'h222, 1, 0, 0, 0, "R5 done while locked");
    step(0, 0, 0, 0, 0, 1, "R5 clear while locked");
    step(1, 10'h333, 0, 0, 0, 0, "R8 flag on dropped result");
    // R6 hi read unlocks, same-cycle done dropped
    step(1, 10'h0F0, 0, 0, 1, 0, "R6 done with hi read");
    step(1, 10'h0F0, 0, 0, 0, 0, "R6 accepted after unlock");
    // R7 hi-only reads keep updating
    step(1, 10'h1A1, 1, 0, 1, 0, "R7 hi only a");
    step(1, 10'h2B2, 1, 0, 1, 0, "R7 hi only b");
    step(1, 10'h3C3, 0, 0, 0, 0, "R7 no lock");
    // R10 both strobes together
    step(1, 10'h155, 0, 1, 1, 0, "R10 both with done");
    step(1, 10'h2AA, 0, 0, 0, 0, "R10 unlocked after");
    // mixed sweep
    for (int k = 0; k < 64; k++) begin
      step(k % 3 != 0, (k * 97 + 13) % 1024, k % 5 == 1, k % 7 == 2, k % 4 == 3,
           k % 6 == 4, "R5 R6 sweep");
    end
    // reset mid-run
    rst_n = 1'b0;
    m_hi = 0; m_lo = 0; m_flag = 0; m_lock = 0;
    @(negedge clk);
    compare("R1 second reset");
    rst_n = 1'b1;
    step(1, 10'h001, 0, 0, 0, 0, "R1 unlocked after reset");

    done_run = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule